// File: doc/BRIEF.md
# Registered Twelve-to-Twenty-Four-Bit Bus Exchanger

This block connects one 12-bit narrow port (A) to a 24-bit wide side made of two 12-bit halves, called the low half (1B) and the high half (2B). In the outbound direction, each half has its own capture register and its own active-low load enable. A host can therefore load two consecutive narrow words, one into each half, and present them together as one wide word. In the return direction, a select line picks one half. The picked value is held in one shared storage register and then re-registered onto the narrow port, so the data stays valid on the bus for a full cycle.

Every control input passes through a sampling stage before it acts: the select, both load enables and the three active-low output enables. The outbound narrow word is sampled alongside them, so a word and its load enable always stay paired. The three-state pads are modelled as a data-out bus plus one drive-enable bit per port. An active-high synchronous reset clears all data registers and turns every drive enable off.

The return path has two selection states, named by the `bx_src_e` enumeration. `SRC_1B` is in force while the sampled select is 0 and routes the low half. `SRC_2B` is in force while the sampled select is 1 and routes the high half. Each edge moves to the state given by the select sampled on the previous edge. Reset forces `SRC_1B`.

Top module: `regbus_exchanger`

## Requirements
- R1: While `rst` is high at a rising edge, all three drive enables are 0 and `a_out`, `b1_out`, `b2_out` are 0 after that edge.
- R2: If `ld1_n` is 0 at edge n, then after edge n+1 `b1_out` equals the `a_in` value present at edge n. If `ld1_n` is 1 at edge n, `b1_out` keeps its value across edge n+1.
- R3: The high half follows the same rule as R2, using `ld2_n` and `b2_out`.
- R4: Suppose `ld1_n` is 0 for word X at edge n, and `ld2_n` is 0 for word Y at edge n+1. Then after edge n+2, `{b2_out, b1_out}` equals `{Y, X}`.
- R5: Suppose `sel` is 0 at edge n. Then after edge n+2, `a_out` equals the `b1_in` value present at edge n+1. With `sel` at 1, it equals `b2_in` instead.
- R6: The half that is not selected has no effect on `a_out`.
- R7: After edge n+1, `a_drive` equals the inverse of `a_oe_n` as sampled at edge n.
- R8: After edge n+1, `b1_drive` and `b2_drive` equal the inverses of `b1_oe_n` and `b2_oe_n` as sampled at edge n.
- R9: Output-enable changes never alter the data-out buses. A half holds its word while all drives are off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Return select: 0 picks the low half, 1 picks the high half |
| ld1_n | input | 1 | Active-low load enable, low half |
| ld2_n | input | 1 | Active-low load enable, high half |
| a_oe_n | input | 1 | Active-low output enable, narrow port |
| b1_oe_n | input | 1 | Active-low output enable, low half |
| b2_oe_n | input | 1 | Active-low output enable, high half |
| a_in | input | 12 | Narrow-port pad input |
| a_out | output | 12 | Narrow-port pad output data |
| a_drive | output | 1 | Narrow-port pad drive enable |
| b1_in | input | 12 | Low-half pad input |
| b1_out | output | 12 | Low-half pad output data |
| b1_drive | output | 1 | Low-half pad drive enable |
| b2_in | input | 12 | High-half pad input |
| b2_out | output | 12 | High-half pad output data |
| b2_drive | output | 1 | High-half pad drive enable |

## Verification
A directed packing sequence loads distinct words into the low half and then the high half, which shows whether each word lands in the half its own enable names. A phase with both enables held off follows, which separates a true hold from a reload. In the return phases, `sel` is held while only the unselected half changes, and then `sel` is toggled every cycle; this exposes swapped selection and a wrong pipeline depth. A long pseudo-random phase, with reset pulses and output-enable changes mixed in, is compared on every edge against a model built from input history arrays. That phase catches off-by-one timing on any registered control.

// File: rtl/bx_pkg.sv
package bx_pkg;

    localparam int BX_HALVES = 2;

    typedef enum logic {
        SRC_1B = 1'b0,
        SRC_2B = 1'b1
    } bx_src_e;

    typedef struct packed {
        bx_src_e              src;
        logic [BX_HALVES-1:0] ld_n;
        logic                 a_oe_n;
        logic [BX_HALVES-1:0] b_oe_n;
    } bx_ctrl_t;

    localparam bx_ctrl_t BX_CTRL_IDLE = '{
        src:    SRC_1B,
        ld_n:   {BX_HALVES{1'b1}},
        a_oe_n: 1'b1,
        b_oe_n: {BX_HALVES{1'b1}}
    };

endpackage

// File: rtl/bx_ctrl_stage.sv
module bx_ctrl_stage
    import bx_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sel,
    input  logic [BX_HALVES-1:0] ld_n,
    input  logic                 a_oe_n,
    input  logic [BX_HALVES-1:0] b_oe_n,
    input  logic [DATA_W-1:0]    a_in,
    output bx_ctrl_t             ctrl_q,
    output logic [DATA_W-1:0]    a_q
);

    // Sampling stage: controls and the outbound word move together
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= BX_CTRL_IDLE;
            a_q    <= '0;
        end else begin
            ctrl_q.src    <= sel ? SRC_2B : SRC_1B;
            ctrl_q.ld_n   <= ld_n;
            ctrl_q.a_oe_n <= a_oe_n;
            ctrl_q.b_oe_n <= b_oe_n;
            a_q           <= a_in;
        end
    end

endmodule

// File: rtl/bx_bport_reg.sv
module bx_bport_reg #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_n,
    input  logic              oe_n,
    input  logic [DATA_W-1:0] d,
    output logic [DATA_W-1:0] q,
    output logic              drive
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q     <= '0;
            drive <= 1'b0;
        end else begin
            if (!load_n) begin
                q <= d;
            end
            drive <= !oe_n;
        end
    end

    AST_HALF_HOLD: assert property (@(posedge clk) disable iff (rst) load_n |=> $stable(q)); // R2, R3
    AST_HALF_DRIVE: assert property (@(posedge clk) disable iff (rst) !rst |=> (drive == !$past(oe_n))); // R8

endmodule

// File: rtl/bx_return_path.sv
module bx_return_path
    import bx_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  bx_src_e           src,
    input  logic [DATA_W-1:0] b1,
    input  logic [DATA_W-1:0] b2,
    input  logic              oe_n,
    output logic [DATA_W-1:0] a_out,
    output logic              a_drive
);

    logic [DATA_W-1:0] pick;
    logic [DATA_W-1:0] held;

    always_comb begin
        unique case (src)
            SRC_1B:  pick = b1;
            SRC_2B:  pick = b2;
            default: pick = b1;
        endcase
    end

    // Shared storage, then the registered narrow output
    always_ff @(posedge clk) begin
        if (rst) begin
            held    <= '0;
            a_out   <= '0;
            a_drive <= 1'b0;
        end else begin
            held    <= pick;
            a_out   <= held;
            a_drive <= !oe_n;
        end
    end

    AST_PICK_LOW: assert property (@(posedge clk) disable iff (rst) (src == SRC_1B) |=> (held == $past(b1))); // R5
    AST_PICK_HIGH: assert property (@(posedge clk) disable iff (rst) (src == SRC_2B) |=> (held == $past(b2))); // R6
    AST_NARROW_DRIVE: assert property (@(posedge clk) disable iff (rst) !rst |=> (a_drive == !$past(oe_n))); // R7

endmodule

// File: rtl/regbus_exchanger.sv
module regbus_exchanger
    import bx_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              ld1_n,
    input  logic              ld2_n,
    input  logic              a_oe_n,
    input  logic              b1_oe_n,
    input  logic              b2_oe_n,
    input  logic [DATA_W-1:0] a_in,
    output logic [DATA_W-1:0] a_out,
    output logic              a_drive,
    input  logic [DATA_W-1:0] b1_in,
    output logic [DATA_W-1:0] b1_out,
    output logic              b1_drive,
    input  logic [DATA_W-1:0] b2_in,
    output logic [DATA_W-1:0] b2_out,
    output logic              b2_drive
);

    localparam int WIDE_W = DATA_W * BX_HALVES;

    bx_ctrl_t          ctrl_q;
    logic [DATA_W-1:0] a_q;
    logic [DATA_W-1:0] half_q [BX_HALVES];
    logic              half_drv [BX_HALVES];
    logic [WIDE_W-1:0] wide_word;

    bx_ctrl_stage #(.DATA_W(DATA_W)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .sel    (sel),
        .ld_n   ({ld2_n, ld1_n}),
        .a_oe_n (a_oe_n),
        .b_oe_n ({b2_oe_n, b1_oe_n}),
        .a_in   (a_in),
        .ctrl_q (ctrl_q),
        .a_q    (a_q)
    );

    for (genvar h = 0; h < BX_HALVES; h++) begin : g_half
        bx_bport_reg #(.DATA_W(DATA_W)) u_half (
            .clk    (clk),
            .rst    (rst),
            .load_n (ctrl_q.ld_n[h]),
            .oe_n   (ctrl_q.b_oe_n[h]),
            .d      (a_q),
            .q      (half_q[h]),
            .drive  (half_drv[h])
        );
        assign wide_word[h*DATA_W +: DATA_W] = half_q[h];
    end

    assign b1_out   = wide_word[0 +: DATA_W];
    assign b2_out   = wide_word[DATA_W +: DATA_W];
    assign b1_drive = half_drv[0];
    assign b2_drive = half_drv[1];

    bx_return_path #(.DATA_W(DATA_W)) u_ret (
        .clk     (clk),
        .rst     (rst),
        .src     (ctrl_q.src),
        .b1      (b1_in),
        .b2      (b2_in),
        .oe_n    (ctrl_q.a_oe_n),
        .a_out   (a_out),
        .a_drive (a_drive)
    );

    AST_LOW_LOAD: assert property (@(posedge clk) disable iff (rst) !ctrl_q.ld_n[0] |=> (b1_out == $past(a_q))); // R2
    AST_HIGH_LOAD: assert property (@(posedge clk) disable iff (rst) !ctrl_q.ld_n[1] |=> (b2_out == $past(a_q))); // R3

endmodule

// File: tb/tb_regbus_exchanger.sv
module tb_regbus_exchanger;

    localparam int W = 12;
    localparam int HN = 1200;

    logic clk = 1'b0;
    logic rst, sel, ld1_n, ld2_n, a_oe_n, b1_oe_n, b2_oe_n;
    logic [W-1:0] a_in, b1_in, b2_in;
    logic [W-1:0] a_out, b1_out, b2_out;
    logic a_drive, b1_drive, b2_drive;

    int checks = 0;
    int fails = 0;
    int k = 0;
    bit done = 0;
    int unsigned lcg = 32'h1234_5678;

    // Input history, one entry per rising edge
    bit     h_rst [HN];
    bit     h_sel [HN];
    bit     h_ld1 [HN];
    bit     h_ld2 [HN];
    bit     h_oa  [HN];
    bit     h_ob1 [HN];
    bit     h_ob2 [HN];
    integer h_a   [HN];
    integer h_b1  [HN];
    integer h_b2  [HN];
    integer e_hold [HN];
    integer eb1 = 0;
    integer eb2 = 0;

    always #2.5 clk = ~clk;

    regbus_exchanger #(.DATA_W(W)) dut (
        .clk(clk), .rst(rst), .sel(sel), .ld1_n(ld1_n), .ld2_n(ld2_n),
        .a_oe_n(a_oe_n), .b1_oe_n(b1_oe_n), .b2_oe_n(b2_oe_n),
        .a_in(a_in), .a_out(a_out), .a_drive(a_drive),
        .b1_in(b1_in), .b1_out(b1_out), .b1_drive(b1_drive),
        .b2_in(b2_in), .b2_out(b2_out), .b2_drive(b2_drive)
    );

    task automatic chk(input string tag, input integer act, input integer exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s cycle=%0d actual=%0h expected=%0h", tag, k, act, exp);
        end
    endtask

    function automatic bit was_rst(input int j);
        return (j < 0) ? 1'b1 : h_rst[j];
    endfunction

    task automatic step(input bit r, input bit s, input bit l1, input bit l2,
                        input bit oa, input bit o1, input bit o2,
                        input integer av, input integer v1, input integer v2);
        integer ea;
        integer stv;
        bit     sq;
        rst = r; sel = s; ld1_n = l1; ld2_n = l2;
        a_oe_n = oa; b1_oe_n = o1; b2_oe_n = o2;
        a_in = av[W-1:0]; b1_in = v1[W-1:0]; b2_in = v2[W-1:0];
        h_rst[k] = r; h_sel[k] = s; h_ld1[k] = l1; h_ld2[k] = l2;
        h_oa[k] = oa; h_ob1[k] = o1; h_ob2[k] = o2;
        h_a[k] = av % (1 << W); h_b1[k] = v1 % (1 << W); h_b2[k] = v2 % (1 << W);
        @(posedge clk);
        @(negedge clk);
        // Model of edge k
        sq  = was_rst(k - 1) ? 1'b0 : h_sel[k-1];
        stv = r ? 0 : (sq ? h_b2[k] : h_b1[k]);
        e_hold[k] = stv;
        ea = (r || k < 1) ? 0 : e_hold[k-1];
        if (r) begin
            eb1 = 0; eb2 = 0;
        end else if (!was_rst(k - 1)) begin
            if (!h_ld1[k-1]) eb1 = h_a[k-1];
            if (!h_ld2[k-1]) eb2 = h_a[k-1];
        end
        if (r) begin
            chk("R1 a_out", a_out, 0);
            chk("R1 b1_out", b1_out, 0);
            chk("R1 b2_out", b2_out, 0);
            chk("R1 a_drive", a_drive, 0);
            chk("R1 b1_drive", b1_drive, 0);
            chk("R1 b2_drive", b2_drive, 0);
        end else begin
            chk("R2 b1_out", b1_out, eb1);
            chk("R3 b2_out", b2_out, eb2);
            chk("R5 a_out", a_out, ea);
            chk("R7 a_drive", a_drive, was_rst(k - 1) ? 0 : !h_oa[k-1]);
            chk("R8 b1_drive", b1_drive, was_rst(k - 1) ? 0 : !h_ob1[k-1]);
            chk("R8 b2_drive", b2_drive, was_rst(k - 1) ? 0 : !h_ob2[k-1]);
        end
        k++;
    endtask

    function automatic int unsigned nxt();
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        return lcg;
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : stim
        @(negedge clk);
        // R1: reset state
        for (int i = 0; i < 3; i++) step(1, 0, 1, 1, 1, 1, 1, 0, 0, 0);
        // R4: pack two sequential words into the wide word
        step(0, 0, 0, 1, 0, 0, 0, 'h3A5, 0, 0);
        step(0, 0, 1, 0, 0, 0, 0, 'hC5A, 0, 0);
        step(0, 0, 1, 1, 0, 0, 0, 'h0FF, 0, 0);
        chk("R4 wide word", {b2_out, b1_out}, {12'hC5A, 12'h3A5});
        // R2/R3 hold with both loads off
        for (int i = 0; i < 3; i++) step(0, 0, 1, 1, 0, 0, 0, 'h111 * (i + 1), 0, 0);
        chk("R2 hold b1", b1_out, 'h3A5);
        chk("R3 hold b2", b2_out, 'hC5A);
        // R9: drives off, data unchanged
        step(0, 0, 1, 1, 1, 1, 1, 'h777, 'h100, 'h200);
        step(0, 0, 1, 1, 1, 1, 1, 'h777, 'h101, 'h201);
        chk("R9 b1 data kept", b1_out, 'h3A5);
        chk("R9 b2 data kept", b2_out, 'hC5A);
        chk("R9 drive off", b1_drive, 0);
        // R6: low half selected, only high half changes
        for (int i = 0; i < 4; i++) step(0, 0, 1, 1, 0, 0, 0, 0, 'h5C3, 'h800 + i);
        chk("R6 unselected ignored", a_out, 'h5C3);
        // R5: toggle select every cycle
        for (int i = 0; i < 8; i++) step(0, i % 2, 1, 1, 0, 0, 0, 0, 'h400 + i, 'hA00 + i);
        chk("R5 high picked", a_out, 'hA06);
        // Mixed pseudo-random traffic with occasional reset
        for (int i = 0; i < 1000; i++) begin
            int unsigned r0 = nxt();
            int unsigned r1 = nxt();
            step((r0 % 97) == 0, r0[3], r0[4], r0[5], r0[6], r0[7], r0[8],
                 r1 % 4096, (r1 >> 12) % 4096, (r0 >> 16) % 4096);
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule